// File: doc/BRIEF.md
# Byte-Stream Register Access Bridge

This block turns a stream of command bytes into 32-bit register transfers on a simple request/acknowledge bus. Each command starts with a fixed 8-byte header. The header names an operation, a 16-bit word count and a 32-bit start address. A read command fetches the requested words over the bus and sends them back on an outgoing byte stream. A write command takes the data bytes that follow the header, packs them into words and writes them to the bus. A close command stops the bridge for good and raises a termination flag.

Both byte streams use a valid/ready handshake. On the register side the bridge holds a request until the target acknowledges it, and it moves exactly one word on each acknowledge. A command with an unknown operation code, or with a count of zero, uses up only its header. The bridge then waits for the next header.

Top module: `reg_cmd_bridge`

## Requirements
- R1: A header is exactly 8 input bytes. Byte 0 is the operation code and byte 1 has no effect. Bytes 2 and 3 form the word count, least significant byte first. Bytes 4 to 7 form the start address, least significant byte first.
- R2: The operation codes are 0x72 for read, 0x77 for write and 0x63 for close.
- R3: A read with count n performs n bus reads and emits exactly 4·n output bytes. Each word goes out least significant byte first.
- R4: A write with count n consumes exactly 4·n input bytes after the header. It assembles each group of four bytes least significant byte first, and it performs n bus writes.
- R5: The bus address begins at the header's start address and grows by 4 after every word transferred.
- R6: A read or write with a count of 0 makes no bus access and emits no byte, and the next 8 input bytes are taken as a new header.
- R7: A header with any other operation code makes no bus access and emits no byte, and the byte that follows it is taken as the first byte of a new header.
- R8: After a close header, `terminated` goes high and stays high until reset. `in_ready` stays low from then on, and no further bus request or output byte is produced.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values. Each cycle in which both are high completes one word.
- R10: After reset, `in_ready` is high and `out_valid`, `bus_req` and `terminated` are low.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Incoming command and write-data byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Bridge accepts an incoming byte |
| out_data | output | 8 | Outgoing read-data byte |
| out_valid | output | 1 | Outgoing byte is valid |
| out_ready | input | 1 | Consumer accepts the outgoing byte |
| bus_req | output | 1 | Register transfer request |
| bus_we | output | 1 | Transfer is a write when high |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with the acknowledge |
| bus_ack | input | 1 | Target completes the transfer this cycle |
| terminated | output | 1 | A close command has been received |

## Verification
The block's state is mainly the header phase, the remaining word count and the running address. An error in any of them shows at the ports within one command. A wrong count shows as a missing or extra word on the bus, or as the next header being framed wrongly, so the data of the following command is corrupted. A wrong address or byte order puts a word in the wrong place, and the read-back of that same command shows it. A framing slip after an ignored or zero-count header shows at once, because the next command misbehaves.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int HDR_BYTES  = 8;
    localparam int HDR_W      = HDR_BYTES * BYTE_W;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = 32;
    localparam int ADDR_STEP  = WORD_BYTES;

    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h72;
    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h77;
    localparam logic [BYTE_W-1:0] OPC_CLOSE = 8'h63;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_WR_GATHER,
        ST_WR_BUS,
        ST_RD_BUS,
        ST_RD_SEND,
        ST_CLOSED
    } state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_CLOSE
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    // Header layout: opcode in the lowest byte, one byte skipped,
    // count and address follow least significant byte first.
    function automatic hdr_t decode_hdr(input logic [HDR_W-1:0] raw);
        hdr_t h;
        unique case (raw[BYTE_W-1:0])
            OPC_READ:  h.cmd = CMD_READ;
            OPC_WRITE: h.cmd = CMD_WRITE;
            OPC_CLOSE: h.cmd = CMD_CLOSE;
            default:   h.cmd = CMD_NONE;
        endcase
        h.count = raw[2*BYTE_W +: CNT_W];
        h.addr  = raw[4*BYTE_W +: ADDR_W];
        return h;
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(ADDR_STEP);
    endfunction

endpackage

// File: rtl/rcb_byte_gather.sv
module rcb_byte_gather
    import rcb_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int VAL_W = NBYTES * BYTE_W,
    localparam int SH_W  = (NBYTES - 1) * BYTE_W,
    localparam int CW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              last_o,
    output logic [VAL_W-1:0]  value_o
);

    logic [CW-1:0]   cnt_q;
    logic [SH_W-1:0] sh_q;

    assign last_o  = take_i && (cnt_q == CW'(NBYTES - 1));
    assign value_o = {byte_i, sh_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (take_i) begin
            sh_q <= {byte_i, sh_q[SH_W-1:BYTE_W]};
            if (last_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/rcb_word_emitter.sv
module rcb_word_emitter
    import rcb_pkg::*;
#(
    localparam int IDX_W = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              done_o
);

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              busy_q;

    assign valid_o = busy_q;
    assign byte_o  = word_q[BYTE_W-1:0];
    assign done_o  = busy_q && ready_i && (idx_q == IDX_W'(WORD_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (load_i) begin
            word_q <= word_i;
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && ready_i) begin
            word_q <= word_q >> BYTE_W;
            idx_q  <= idx_q + IDX_W'(1);
            if (done_o) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/reg_cmd_bridge.sv
module reg_cmd_bridge
    import rcb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    output logic        terminated
);

    state_e            state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [WORD_W-1:0] wdata_q;

    logic              hdr_take, hdr_last;
    logic [HDR_W-1:0]  hdr_raw;
    hdr_t              hdr;
    logic              wr_take, wr_last;
    logic [WORD_W-1:0] wr_word;
    logic              emit_load, emit_done;
    logic              last_word;

    assign in_ready  = (state_q == ST_HDR) || (state_q == ST_WR_GATHER);
    assign hdr_take  = in_valid && (state_q == ST_HDR);
    assign wr_take   = in_valid && (state_q == ST_WR_GATHER);
    assign hdr       = decode_hdr(hdr_raw);
    assign last_word = (remain_q == CNT_W'(1));
    assign emit_load = (state_q == ST_RD_BUS) && bus_ack;

    assign bus_req    = (state_q == ST_WR_BUS) || (state_q == ST_RD_BUS);
    assign bus_we     = (state_q == ST_WR_BUS);
    assign bus_addr   = addr_q;
    assign bus_wdata  = wdata_q;
    assign terminated = (state_q == ST_CLOSED);

    rcb_byte_gather #(.NBYTES(HDR_BYTES)) hdr_gather_i (
        .clk     (clk),
        .rst     (rst),
        .take_i  (hdr_take),
        .byte_i  (in_data),
        .last_o  (hdr_last),
        .value_o (hdr_raw)
    );

    rcb_byte_gather #(.NBYTES(WORD_BYTES)) word_gather_i (
        .clk     (clk),
        .rst     (rst),
        .take_i  (wr_take),
        .byte_i  (in_data),
        .last_o  (wr_last),
        .value_o (wr_word)
    );

    rcb_word_emitter emitter_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (emit_load),
        .word_i  (bus_rdata),
        .ready_i (out_ready),
        .valid_o (out_valid),
        .byte_o  (out_data),
        .done_o  (emit_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HDR;
            addr_q   <= '0;
            remain_q <= '0;
            wdata_q  <= '0;
        end else begin
            unique case (state_q)
                ST_HDR: begin
                    if (hdr_last) begin
                        addr_q   <= hdr.addr;
                        remain_q <= hdr.count;
                        unique case (hdr.cmd)
                            CMD_READ:  state_q <= (hdr.count == '0) ? ST_HDR : ST_RD_BUS;
                            CMD_WRITE: state_q <= (hdr.count == '0) ? ST_HDR : ST_WR_GATHER;
                            CMD_CLOSE: state_q <= ST_CLOSED;
                            default:   state_q <= ST_HDR;
                        endcase
                    end
                end
                ST_WR_GATHER: begin
                    if (wr_last) begin
                        wdata_q <= wr_word;
                        state_q <= ST_WR_BUS;
                    end
                end
                ST_WR_BUS: begin
                    if (bus_ack) begin
                        addr_q   <= step_addr(addr_q);
                        remain_q <= remain_q - CNT_W'(1);
                        state_q  <= last_word ? ST_HDR : ST_WR_GATHER;
                    end
                end
                ST_RD_BUS: begin
                    if (bus_ack) begin
                        state_q <= ST_RD_SEND;
                    end
                end
                ST_RD_SEND: begin
                    if (emit_done) begin
                        addr_q   <= step_addr(addr_q);
                        remain_q <= remain_q - CNT_W'(1);
                        state_q  <= last_word ? ST_HDR : ST_RD_BUS;
                    end
                end
                default: state_q <= ST_CLOSED;
            endcase
        end
    end

endmodule

// File: rtl/reg_cmd_bridge_checker.sv
module reg_cmd_bridge_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic [7:0]  out_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        terminated
);

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_close_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        terminated |=> terminated);

    assert_close_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        terminated |-> !in_ready && !bus_req && !out_valid);

    assert_write_no_input_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we |-> !in_ready && !out_valid);

    assert_read_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !bus_req && !in_ready);

endmodule

bind reg_cmd_bridge reg_cmd_bridge_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .terminated (terminated)
);

// File: tb/reg_cmd_bridge_tb_top.sv
`timescale 1ns/100ps
module reg_cmd_bridge_tb_top;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int          NW   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        terminated;

    logic [31:0] mem     [NW];
    logic [31:0] ref_mem [NW];
    logic [7:0]  rxq[$];
    int          bus_cnt = 0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    reg_cmd_bridge dut_i (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .terminated(terminated)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Register target model: decides the acknowledge at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                bus_ack = 1'b0;
            end else if (bus_req && ($urandom % 3 != 0)) begin
                if (bus_addr[31:8] !== BASE[31:8] || bus_addr[1:0] !== 2'b00)
                    chk("R5", "bus address in window", bus_addr, BASE);
                if (bus_we) mem[bus_addr[7:2]] = bus_wdata;
                else        bus_rdata = mem[bus_addr[7:2]];
                bus_cnt++;
                bus_ack = 1'b1;
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    // Output consumer with random back-pressure.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 4 != 0);
            if (out_ready && out_valid) rxq.push_back(out_data);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic push(input logic [7:0] b, input int limit, output bit ok);
        int waited = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready && waited < limit) begin
            @(negedge clk);
            waited++;
        end
        ok = in_ready;
        if (ok) @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [15:0] n, input logic [31:0] a);
        bit ok;
        logic [63:0] h;
        h = {a, n, 8'($urandom), op};
        for (int i = 0; i < 8; i++) push(h[i*8 +: 8], 2000, ok);
    endtask

    task automatic wait_bus(input int target);
        int t = 0;
        while (bus_cnt < target && t < 5000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input int idx, input int n, input bit directed);
        bit ok;
        int start = bus_cnt;
        send_hdr(8'h77, 16'(n), BASE + 32'(idx * 4));
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            w = directed ? 32'h4433_2211 : $urandom;
            ref_mem[idx + k] = w;
            for (int b = 0; b < 4; b++) push(w[b*8 +: 8], 2000, ok);
        end
        wait_bus(start + n);
        chk("R4", "bus writes for a write command", bus_cnt - start, n);
        for (int k = 0; k < n; k++)
            chk("R5", $sformatf("word %0d after write", idx + k), mem[idx + k], ref_mem[idx + k]);
    endtask

    task automatic do_read(input int idx, input int n);
        int t = 0;
        int start = bus_cnt;
        rxq.delete();
        send_hdr(8'h72, 16'(n), BASE + 32'(idx * 4));
        while (rxq.size() < 4 * n && t < 10000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
        chk("R3", "bytes returned by read", rxq.size(), 4 * n);
        chk("R3", "bus reads for a read command", bus_cnt - start, n);
        if (rxq.size() == 4 * n)
            for (int k = 0; k < n; k++)
                chk("R3", $sformatf("read word %0d", idx + k),
                    {rxq[4*k+3], rxq[4*k+2], rxq[4*k+1], rxq[4*k]}, ref_mem[idx + k]);
    endtask

    initial begin
        bit ok;
        int s;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) begin
            mem[i] = $urandom;
            ref_mem[i] = mem[i];
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10 reset state
        chk("R10", "in_ready after reset", in_ready, 1);
        chk("R10", "out_valid after reset", out_valid, 0);
        chk("R10", "bus_req after reset", bus_req, 0);
        chk("R10", "terminated after reset", terminated, 0);

        // R1 R4 directed little-endian write, R3 read back
        do_write(4, 1, 1'b1);
        chk("R1", "LE assembled word", mem[4], 32'h4433_2211);
        rxq.delete();
        do_read(4, 1);
        if (rxq.size() >= 1) chk("R3", "first byte out is LSB", rxq[0], 8'h11);

        // R2 R5 randomised bursts
        for (int it = 0; it < 24; it++) begin
            int n   = 1 + ($urandom % 6);
            int idx = $urandom % (NW - n);
            if ($urandom % 2) do_write(idx, n, 1'b0);
            else              do_read(idx, n);
        end
        do_write(60, 4, 1'b0);
        do_read(60, 4);

        // R6 zero count
        s = bus_cnt;
        rxq.delete();
        send_hdr(8'h77, 16'd0, BASE);
        send_hdr(8'h72, 16'd0, BASE);
        repeat (10) @(negedge clk);
        chk("R6", "bus accesses for zero count", bus_cnt - s, 0);
        chk("R6", "bytes out for zero count", rxq.size(), 0);
        chk("R6", "in_ready after zero count", in_ready, 1);
        do_read(10, 2);

        // R7 unknown opcode, count not consumed
        s = bus_cnt;
        rxq.delete();
        send_hdr(8'h78, 16'd3, BASE + 32'd8);
        repeat (10) @(negedge clk);
        chk("R7", "bus accesses for unknown opcode", bus_cnt - s, 0);
        chk("R7", "bytes out for unknown opcode", rxq.size(), 0);
        chk("R7", "in_ready after unknown opcode", in_ready, 1);
        do_read(2, 3);

        // R8 close
        s = bus_cnt;
        send_hdr(8'h63, 16'd5, BASE);
        repeat (5) @(negedge clk);
        chk("R8", "terminated after close", terminated, 1);
        chk("R8", "in_ready after close", in_ready, 0);
        push(8'h72, 40, ok);
        chk("R8", "byte accepted after close", ok, 0);
        chk("R8", "bus accesses after close", bus_cnt - s, 0);
        chk("R8", "terminated stays high", terminated, 1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule